// File: doc/BRIEF.md
# Multi-channel addressable PWM generator

This block produces a set of pulse-width-modulated outputs that all run at one common frame rate. A shared prescaler divides the system clock by a fixed divisor and produces one tick every `DIV` cycles. Each tick advances a shared `RES`-bit frame counter. As a result, one full PWM frame lasts `DIV * 2^RES` clock cycles. Only the pulse width changes from one setting to the next. The frame length never changes.

Each channel holds its own duty value, written as a fraction `duty / 2^RES`. The duty word is `RES+1` bits wide, so the value `2^RES` can be written to request a fully-on output. Software or a neighbouring block writes a duty through a single valid/ready port that carries a channel index. The value first lands in a pending register for that channel. It moves into the live register only when the frame counter wraps. Because of this, a frame that is already running is never cut short and never lengthened. Every output is registered.

The write port never applies back-pressure: `wr_ready` stays high whenever the block is out of reset. A write takes effect on every clock edge where `wr_valid` and `wr_ready` are both high. There is no response channel.

Top module: `pwm_multi_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the prescaler, the frame counter and every pending and live duty register. All outputs are low while reset is held, and they stay low for the first frame after release.
- R2: The frame counter advances by one only on a prescaler tick, and a tick occurs once every `DIV` cycles. The counter wraps from `2^RES-1` to 0, so a frame is `DIV * 2^RES` cycles and every rising edge of any output lies on a frame boundary.
- R3: Within a frame, channel i is high while the frame counter is below its live duty d (with 0 < d < 2^RES). It is therefore high for the first `d * DIV` cycles of the frame and low for the rest, so it falls `d * DIV` cycles after the frame starts.
- R4: A live duty of 0 keeps the channel low for the whole frame.
- R5: A live duty of `2^RES` or more keeps the channel high for the whole frame. Every duty value from `2^RES` up to `2^(RES+1)-1` counts as fully on.
- R6: `wr_ready` is 1 whenever the block is out of reset. A write is accepted on every edge where `wr_valid` is high.
- R7: An accepted write updates only the pending duty of the channel given by `wr_addr`. A write whose `wr_addr` is `CH` or higher changes no register and no output. If a channel is written several times in one frame, the last value wins.
- R8: A written duty takes effect from the first frame that starts after the write. The live duty changes only at the counter wrap, so the frame in progress keeps its old duty.
- R9: Outputs are registered. An output reflects the comparison against the counter value one clock later: it rises on the first cycle after the counter has shown 0 for one edge, which is the first cycle of the frame as seen at the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Duty write request |
| wr_ready | output | 1 | Write acceptance, always 1 out of reset |
| wr_addr | input | max(1, ceil(log2(CH))) | Channel index of the write |
| wr_duty | input | RES+1 | Duty value, in units of 1/2^RES |
| pwm_out | output | CH | PWM outputs, bit i is channel i |

## Verification
A write captured at the edge that follows the cycle in which it is driven has no visible effect until the next frame boundary. The scoreboard therefore pairs each frame with the duty set that was pending at the end of the frame before it. The edge after release of reset is taken as cycle 0. Counting from there, with frame length P, a rising edge appears at the port only on cycles whose index modulo P is 0, and a channel with live duty d falls on cycle `d*DIV` of its frame. The bench checks both positions and the total high-cycle count of each frame. All writes are issued early in a frame, at phase 2, well clear of the wrap edge, so every expectation belongs to exactly one frame.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;

  // Number of bits needed to hold the values 0 .. n-1, with at least one bit
  function automatic int width_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV = 7812
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = pwm_multi_pkg::width_for(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
  parameter int RES = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  output logic [RES-1:0] cnt,
  output logic           wrap
);
  logic [RES-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = tick && (cnt_q == '1);
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
  parameter int CH  = 4,
  parameter int RES = 8,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [AW-1:0]     wr_addr,
  input  logic [RES:0]      wr_duty,
  input  logic              wrap,
  output logic [CH*(RES+1)-1:0] pend_flat,
  output logic [CH*(RES+1)-1:0] live_flat
);
  localparam int DW = RES + 1;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [DW-1:0] pend_q;
    logic [DW-1:0] live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= '0;
        live_q <= '0;
      end else begin
        if (wr_fire && (wr_addr == AW'(g))) begin
          pend_q <= wr_duty;
        end
        if (wrap) begin
          live_q <= pend_q;
        end
      end
    end

    assign pend_flat[g*DW +: DW] = pend_q;
    assign live_flat[g*DW +: DW] = live_q;
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CH  = 4,
  parameter int RES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RES-1:0]        cnt,
  input  logic [CH*(RES+1)-1:0] live_flat,
  output logic [CH-1:0]         pwm_out
);
  localparam int DW = RES + 1;

  for (genvar g = 0; g < CH; g++) begin : g_cmp
    logic out_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q <= 1'b0;
      end else begin
        out_q <= ({1'b0, cnt} < live_flat[g*DW +: DW]);
      end
    end

    assign pwm_out[g] = out_q;
  end
endmodule

// File: rtl/pwm_multi_gen.sv
module pwm_multi_gen
  import pwm_multi_pkg::*;
#(
  parameter int RES = 8,
  parameter int DIV = 7812,
  parameter int CH  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [width_for(CH)-1:0] wr_addr,
  input  logic [RES:0]             wr_duty,
  output logic [CH-1:0]            pwm_out
);
  localparam int AW = width_for(CH);
  localparam int DW = RES + 1;

  logic                 tick_w;
  logic                 wrap_w;
  logic [RES-1:0]       cnt_w;
  logic [CH*DW-1:0]     pend_w;
  logic [CH*DW-1:0]     live_w;
  logic                 addr_ok;
  logic                 wr_fire;

  assign wr_ready = 1'b1;
  assign addr_ok  = ({{(32-AW){1'b0}}, wr_addr} < 32'(CH));
  assign wr_fire  = wr_valid && wr_ready && addr_ok;

  pwm_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w)
  );

  pwm_frame_counter #(.RES(RES)) u_frame (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w),
    .cnt  (cnt_w),
    .wrap (wrap_w)
  );

  pwm_duty_bank #(.CH(CH), .RES(RES), .AW(AW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_duty   (wr_duty),
    .wrap      (wrap_w),
    .pend_flat (pend_w),
    .live_flat (live_w)
  );

  pwm_compare #(.CH(CH), .RES(RES)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt_w),
    .live_flat (live_w),
    .pwm_out   (pwm_out)
  );
endmodule

// File: rtl/pwm_multi_gen_chk.sv
module pwm_multi_gen_chk #(
  parameter int RES = 8,
  parameter int CH  = 4,
  parameter int AW  = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_valid,
  input logic [AW-1:0]         wr_addr,
  input logic                  tick,
  input logic [RES-1:0]        cnt,
  input logic [CH*(RES+1)-1:0] pend_flat,
  input logic [CH*(RES+1)-1:0] live_flat,
  input logic [CH-1:0]         pwm_out
);
  logic bad_addr;
  assign bad_addr = wr_valid && ({{(32-AW){1'b0}}, wr_addr} >= 32'(CH));

  // R1: right after reset release every output is low
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pwm_out == '0));

  // R2: counter holds between ticks
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R2: counter steps by one on a tick, wrapping at the top
  p_step_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == RES'($past(cnt) + 1'b1)));

  // R8: live duties change only at the frame wrap
  p_live_only_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    !(tick && (cnt == '1)) |=> $stable(live_flat));

  // R7: out-of-range writes leave pending duties untouched
  p_ignore_bad_addr_r7: assert property (@(posedge clk) disable iff (rst)
    bad_addr |=> $stable(pend_flat));

  // R3 / R9: a rising output follows a counter value of zero
  for (genvar g = 0; g < CH; g++) begin : g_rise
    p_rise_at_frame_start_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out[g]) |-> ($past(cnt) == '0));
  end
endmodule

bind pwm_multi_gen pwm_multi_gen_chk #(.RES(RES), .CH(CH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .tick      (tick_w),
  .cnt       (cnt_w),
  .pend_flat (pend_w),
  .live_flat (live_w),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_multi_gen_bench.sv
module pwm_multi_gen_bench;
  localparam int RES  = 3;
  localparam int DIV  = 2;
  localparam int CH   = 3;
  localparam int AW   = 2;
  localparam int DW   = RES + 1;
  localparam int FULL = 1 << RES;
  localparam int P    = DIV * FULL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_duty = '0;
  logic          wr_ready;
  logic [CH-1:0] pwm_out;

  int total = 0;
  int bad = 0;
  int kc = -1;
  bit finished = 1'b0;

  logic [CH*DW-1:0] sb_q[$];
  logic [CH*DW-1:0] model_pend = '0;
  logic [CH*DW-1:0] cur = '0;
  int               hc[CH];
  logic [CH-1:0]    prev = '0;

  always #5 clk = ~clk;

  pwm_multi_gen #(.RES(RES), .DIV(DIV), .CH(CH)) u_pwm_multi_gen (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_duty  (wr_duty),
    .pwm_out  (pwm_out)
  );

  // cycle index: edge after reset release is 0
  always @(posedge clk) if (!rst) kc <= kc + 1;

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int hi_cycles(input int d);
    return ((d >= FULL) ? FULL : d) * DIV;
  endfunction

  // Monitor: pops the expected duty set at each frame start, compares at frame end
  always @(negedge clk) begin
    int ph;
    int d;
    if (!rst && kc >= 0 && !finished) begin
      ph = kc % P;
      if (ph == 0) begin
        cur = sb_q.pop_front();
        for (int c = 0; c < CH; c++) hc[c] = 0;
      end
      for (int c = 0; c < CH; c++) begin
        d = int'(cur[c*DW +: DW]);
        if (pwm_out[c]) hc[c]++;
        if (pwm_out[c] && !prev[c])
          check("R9", ph, 0, $sformatf("ch%0d rise phase (R2 frame boundary)", c));
        if (!pwm_out[c] && prev[c])
          check("R3", ph, hi_cycles(d) % P, $sformatf("ch%0d fall phase", c));
        prev[c] = pwm_out[c];
      end
      if (ph == P - 1) begin
        for (int c = 0; c < CH; c++) begin
          d = int'(cur[c*DW +: DW]);
          check((d == 0) ? "R4" : ((d >= FULL) ? "R5" : "R3"), hc[c], hi_cycles(d),
                $sformatf("ch%0d frame %0d high cycles, duty %0d (R7 R8 update rules)",
                          c, kc / P, d));
        end
        sb_q.push_back(model_pend);
      end
    end
  end

  // Driver: issues one write and records it in the expected pending set
  task automatic put(input int a, input int d);
    wr_valid = 1'b1;
    wr_addr  = AW'(a);
    wr_duty  = DW'(d);
    if (a < CH) model_pend[a*DW +: DW] = DW'(d);
    @(negedge clk);
    check("R6", int'(wr_ready), 1, "ready while writing");
    wr_valid = 1'b0;
  endtask

  task automatic to_phase2();
    do @(negedge clk); while (kc < 0 || (kc % P) != 2);
  endtask

  initial begin
    sb_q.push_back('0);  // R1: first frame runs with cleared duties
    for (int c = 0; c < CH; c++) hc[c] = 0;
    repeat (3) begin
      @(negedge clk);
      check("R1", int'(pwm_out), 0, "outputs during reset");
    end
    rst = 1'b0;
    @(negedge clk);
    check("R6", int'(wr_ready), 1, "ready after reset");
    to_phase2(); put(0, 3); put(1, 8); put(2, 0);
    to_phase2(); put(1, 5); put(3, 7);            // R7: address 3 ignored
    to_phase2(); put(2, 15); put(0, 1);           // R5: above full scale
    to_phase2(); put(0, 7); put(1, 0); put(3, 1);
    to_phase2(); put(3, 2);
    to_phase2(); put(2, 4); put(2, 6);            // R7: last write wins
    repeat (3 * P) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule